// File: doc/BRIEF.md
# DMA Event Trigger and Queue Manager

This block collects transfer requests for a set of DMA channels and turns them into channel numbers waiting in a small number of prioritized event queues. A regular channel can be started in three ways: a software set pulse, an external event line, or the completion of another transfer that is chained to it. A quick channel has no event line. It starts when software writes one chosen word of its descriptor. Each channel holds at most one pending event. A trigger that arrives while the channel already has a pending event is dropped and recorded as a missed event.

Every channel is steered to one queue by a configuration field. Each cycle, every queue that has room takes the lowest-numbered pending channel mapped to it. The queues feed one shared output port with a valid/ready handshake. When several queues hold entries, the queue with the smallest programmed priority value drives the port. The port also reports which queue supplied the channel, so the matching transfer engine can take it. For each queue the block shows its occupancy and its high watermark. It also raises a flag once the watermark reaches a programmable threshold.

Top module: `dma_evt_qmgr`

## Requirements
- R1: After a synchronous active-low reset, no channel is pending, every missed bit is 0, every queue fill and watermark is 0, and `out_valid` is 0.
- R2: A 1 on `man_set[i]`, `ext_evt[i]` or `chain_done[i]` in a cycle marks regular channel i pending. Several sources in the same cycle count as one event. With room in its queue and nothing ahead of it, channel i appears on `out_ch` after the second rising edge.
- R3: Quick channel q (event id NUM_CH+q) is triggered only by a cycle with `qd_wr_en`=1, `qd_wr_ch`=q and `qd_wr_word`=TRIG_WORD. A write to any other word has no effect.
- R4: A trigger for a channel that is already pending sets bit `miss[i]` at the next edge and adds no event. A 1 on `miss_clr[i]` clears the bit, but a new miss in the same cycle takes precedence and keeps it set.
- R5: Each cycle, each queue with room takes the lowest-numbered pending channel whose `cfg_qmap` field (bits [i*QW +: QW]) equals the queue index. At most one channel enters each queue per cycle.
- R6: A queue whose fill equals DEPTH accepts nothing. Its channels stay pending and are not lost, and the fill never exceeds DEPTH. A push and a pop in the same cycle are allowed only when the queue is not full.
- R7: `out_valid` is 1 whenever any queue is non-empty. `out_q` is the non-empty queue with the smallest `cfg_qprio` value (field [q*PRIO_W +: PRIO_W]), with ties going to the lower index. `out_ch` is that queue's oldest entry, and it is removed when `out_ready` is 1.
- R8: `q_wmark` for queue q equals the largest fill seen since reset or the last clear. A 1 on `wm_clr[q]` loads it with the fill that results from that cycle.
- R9: `q_thr_hit[q]` is 1 exactly when the queue's watermark is greater than or equal to its `cfg_qthresh` field, so a threshold of 0 keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| man_set | input | NUM_CH | Software set pulses, one per regular channel |
| ext_evt | input | NUM_CH | External event pulses |
| chain_done | input | NUM_CH | Chained-completion pulses |
| qd_wr_en | input | 1 | Descriptor write strobe for quick channels |
| qd_wr_ch | input | QCW | Quick channel being written |
| qd_wr_word | input | WW | Descriptor word index being written |
| miss_clr | input | NT | Write-one-to-clear for missed bits |
| cfg_qmap | input | NT*QW | Queue number for each channel |
| cfg_qprio | input | NUM_Q*PRIO_W | Priority per queue, lower value wins |
| cfg_qthresh | input | NUM_Q*CW | Occupancy threshold per queue |
| wm_clr | input | NUM_Q | Write-one-to-clear for watermarks |
| out_valid | output | 1 | A channel number is offered |
| out_ch | output | ID_W | Offered channel number |
| out_q | output | QW | Queue that supplies it |
| out_ready | input | 1 | Transfer engine takes the offer |
| miss | output | NT | Missed-event bits |
| q_fill | output | NUM_Q*CW | Current occupancy per queue |
| q_wmark | output | NUM_Q*CW | Highest occupancy per queue |
| q_thr_hit | output | NUM_Q | Watermark has reached threshold |

## Verification
The bench retriggers a channel on the cycle after its first trigger, when the event is still pending. A design that judged the miss from the next state would enqueue the channel twice instead of setting the missed bit. It also steers every channel to one queue with the output stalled. A design that dropped events at a full queue, or let the fill exceed the depth, would then deliver fewer channels during the drain or report a bad fill. Tied queue priorities, simultaneous clear and miss, a watermark clear while the queue is filling, and a zero threshold are all covered. A wrong tie-break, a clear that wins over a miss, or a watermark loaded from the old fill each shows up as a mismatch against the reference model in that cycle.

// File: rtl/dtq_pkg.sv
// Package: shared types for the DMA event trigger and queue manager.
// Assumes: nothing beyond IEEE 1800-2017.
package dtq_pkg;
    // Queue operation in one cycle, encoded as {push, pop}
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } fifo_op_e;
endpackage

// File: rtl/dtq_trigger.sv
// Module: dtq_trigger
// Merges software, external, chained and descriptor-write triggers into one
// request per channel, keeps one pending event per channel and records
// missed events. Assumes `take` only names channels that are pending.
module dtq_trigger #(
    parameter int NUM_CH    = 16,
    parameter int NUM_QCH   = 4,
    parameter int QCW       = 2,
    parameter int WW        = 3,
    parameter int TRIG_WORD = 7,
    localparam int NT       = NUM_CH + NUM_QCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] man_set,
    input  logic [NUM_CH-1:0] ext_evt,
    input  logic [NUM_CH-1:0] chain_done,
    input  logic              qd_wr_en,
    input  logic [QCW-1:0]    qd_wr_ch,
    input  logic [WW-1:0]     qd_wr_word,
    input  logic [NT-1:0]     take,
    input  logic [NT-1:0]     miss_clr,
    output logic [NT-1:0]     pend,
    output logic [NT-1:0]     miss
);
    logic [NT-1:0] trig;
    logic          word_hit;

    // Regular channels: any of the three sources raises the request
    assign trig[NUM_CH-1:0] = man_set | ext_evt | chain_done;
    // Quick channels fire only on the designated descriptor word
    assign word_hit = qd_wr_en && (qd_wr_word == WW'(TRIG_WORD));

    genvar gq;
    for (gq = 0; gq < NUM_QCH; gq++) begin : g_quick
        // Decode the written quick channel
        assign trig[NUM_CH+gq] = word_hit && (qd_wr_ch == QCW'(gq));
    end

    // Pending and missed state; a retrigger of a pending channel is a miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            miss <= '0;
        end else begin
            pend <= (pend & ~take) | (trig & ~pend);
            miss <= (miss & ~miss_clr) | (trig & pend);
        end
    end

    // R4: a trigger on a pending channel is recorded at the next edge
    p_miss_on_retrig_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig & pend) != '0) |=> ((miss & $past(trig & pend)) == $past(trig & pend)));
    // R5: the arbiter only removes channels that are pending
    p_take_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((take & ~pend) == '0));
endmodule

// File: rtl/dtq_arb.sv
// Module: dtq_arb
// For each queue, picks the lowest-numbered pending channel mapped to it,
// when that queue has room. Assumes each channel maps to exactly one queue.
module dtq_arb #(
    parameter int NT    = 20,
    parameter int NUM_Q = 4,
    parameter int QW    = 2,
    parameter int ID_W  = 5
) (
    input  logic [NT-1:0]         pend,
    input  logic [NT*QW-1:0]      qmap,
    input  logic [NUM_Q-1:0]      room,
    output logic [NT-1:0]         take,
    output logic [NUM_Q-1:0]      push,
    output logic [NUM_Q*ID_W-1:0] push_id
);
    logic [NUM_Q-1:0][NT-1:0] hit;

    genvar gq;
    for (gq = 0; gq < NUM_Q; gq++) begin : g_q
        logic [NT-1:0]   elig;
        logic [NT-1:0]   low;
        logic [ID_W-1:0] id;

        // Channels pending and steered to this queue
        always_comb begin
            for (int i = 0; i < NT; i++) begin
                elig[i] = pend[i] && (qmap[i*QW +: QW] == QW'(gq));
            end
        end

        // Isolate the lowest eligible channel when the queue has room
        assign low = room[gq] ? (elig & (~elig + 1'b1)) : '0;

        // Encode the winner's channel number
        always_comb begin
            id = '0;
            for (int i = 0; i < NT; i++) begin
                if (low[i]) id = ID_W'(i);
            end
        end

        assign hit[gq]                    = low;
        assign push[gq]                   = |low;
        assign push_id[gq*ID_W +: ID_W]   = id;
    end

    // Combine the per-queue winners into one removal mask
    always_comb begin
        take = '0;
        for (int q = 0; q < NUM_Q; q++) take = take | hit[q];
    end
endmodule

// File: rtl/dtq_fifo.sv
// Module: dtq_fifo
// One event queue of channel numbers with fill count, high watermark and
// threshold flag. Assumes push only when not full and pop only when not empty.
module dtq_fifo
    import dtq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int ID_W  = 5,
    parameter int CW    = 3,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    input  logic            wm_clr,
    input  logic [CW-1:0]   thresh,
    output logic [ID_W-1:0] head,
    output logic [CW-1:0]   fill,
    output logic [CW-1:0]   wm,
    output logic            thr_hit
);
    logic [ID_W-1:0] mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   fill_n;
    fifo_op_e        op;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Next occupancy from this cycle's push and pop
    always_comb begin
        op = fifo_op_e'({push, pop});
        unique case (op)
            OP_PUSH: fill_n = fill + 1'b1;
            OP_POP:  fill_n = fill - 1'b1;
            default: fill_n = fill;
        endcase
    end

    // Entry storage, written at the tail
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_id;
    end

    // Pointers, fill and watermark
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            wm     <= '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            fill <= fill_n;
            if (wm_clr)            wm <= fill_n;
            else if (fill_n > wm)  wm <= fill_n;
        end
    end

    assign head    = mem[rd_ptr];
    assign thr_hit = (wm >= thresh);

    // R6: no push into a full queue
    p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (fill < CW'(DEPTH)));
    // R6: fill stays within depth
    p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));
    // R7: no pop from an empty queue
    p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (fill != '0));
    // R8: the watermark always covers the current fill
    p_wm_covers_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wm >= fill);
endmodule

// File: rtl/dtq_outsel.sv
// Module: dtq_outsel
// Chooses which non-empty queue drives the shared output port, by lowest
// programmed priority value and then lowest index. Assumes NUM_Q is 2 or 4.
module dtq_outsel #(
    parameter int NUM_Q  = 4,
    parameter int QW     = 2,
    parameter int PRIO_W = 3
) (
    input  logic [NUM_Q-1:0]        nonempty,
    input  logic [NUM_Q*PRIO_W-1:0] prio,
    input  logic                    out_ready,
    output logic                    out_valid,
    output logic [QW-1:0]           out_q,
    output logic [NUM_Q-1:0]        pop
);
    logic [PRIO_W-1:0] best_p;

    // Scan queues in index order, keeping the strictly better priority
    always_comb begin
        out_valid = 1'b0;
        out_q     = '0;
        best_p    = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            if (nonempty[q] && (!out_valid || (prio[q*PRIO_W +: PRIO_W] < best_p))) begin
                out_valid = 1'b1;
                out_q     = QW'(q);
                best_p    = prio[q*PRIO_W +: PRIO_W];
            end
        end
    end

    // Remove the offered entry on a handshake
    always_comb begin
        pop = '0;
        if (out_valid && out_ready) pop[out_q] = 1'b1;
    end
endmodule

// File: rtl/dma_evt_qmgr.sv
// Module: dma_evt_qmgr (top)
// DMA event trigger and queue manager: trigger merge, per-queue arbitration,
// NUM_Q event queues and a shared prioritized output port.
// Assumes NUM_Q is 2 or 4 and channel ids NUM_CH.. belong to quick channels.
module dma_evt_qmgr #(
    parameter int NUM_CH    = 16,
    parameter int NUM_QCH   = 4,
    parameter int NUM_Q     = 4,
    parameter int DEPTH     = 4,
    parameter int PRIO_W    = 3,
    parameter int NUM_WORDS = 8,
    parameter int TRIG_WORD = 7,
    localparam int NT       = NUM_CH + NUM_QCH,
    localparam int ID_W     = $clog2(NT),
    localparam int QW       = $clog2(NUM_Q),
    localparam int QCW      = (NUM_QCH > 1) ? $clog2(NUM_QCH) : 1,
    localparam int WW       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       man_set,
    input  logic [NUM_CH-1:0]       ext_evt,
    input  logic [NUM_CH-1:0]       chain_done,
    input  logic                    qd_wr_en,
    input  logic [QCW-1:0]          qd_wr_ch,
    input  logic [WW-1:0]           qd_wr_word,
    input  logic [NT-1:0]           miss_clr,
    input  logic [NT*QW-1:0]        cfg_qmap,
    input  logic [NUM_Q*PRIO_W-1:0] cfg_qprio,
    input  logic [NUM_Q*CW-1:0]     cfg_qthresh,
    input  logic [NUM_Q-1:0]        wm_clr,
    output logic                    out_valid,
    output logic [ID_W-1:0]         out_ch,
    output logic [QW-1:0]           out_q,
    input  logic                    out_ready,
    output logic [NT-1:0]           miss,
    output logic [NUM_Q*CW-1:0]     q_fill,
    output logic [NUM_Q*CW-1:0]     q_wmark,
    output logic [NUM_Q-1:0]        q_thr_hit
);
    logic [NT-1:0]         pend, take;
    logic [NUM_Q-1:0]      room, nonempty, push, pop;
    logic [NUM_Q*ID_W-1:0] push_id;
    logic [ID_W-1:0]       head [NUM_Q];

    dtq_trigger #(
        .NUM_CH(NUM_CH), .NUM_QCH(NUM_QCH), .QCW(QCW), .WW(WW), .TRIG_WORD(TRIG_WORD)
    ) i_trig (
        .clk(clk), .rst_n(rst_n), .man_set(man_set), .ext_evt(ext_evt),
        .chain_done(chain_done), .qd_wr_en(qd_wr_en), .qd_wr_ch(qd_wr_ch),
        .qd_wr_word(qd_wr_word), .take(take), .miss_clr(miss_clr),
        .pend(pend), .miss(miss)
    );

    dtq_arb #(.NT(NT), .NUM_Q(NUM_Q), .QW(QW), .ID_W(ID_W)) i_arb (
        .pend(pend), .qmap(cfg_qmap), .room(room),
        .take(take), .push(push), .push_id(push_id)
    );

    genvar gq;
    for (gq = 0; gq < NUM_Q; gq++) begin : g_fifo
        logic [CW-1:0] fill_l;

        dtq_fifo #(.DEPTH(DEPTH), .ID_W(ID_W), .CW(CW)) i_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(push[gq]), .push_id(push_id[gq*ID_W +: ID_W]),
            .pop(pop[gq]), .wm_clr(wm_clr[gq]),
            .thresh(cfg_qthresh[gq*CW +: CW]),
            .head(head[gq]), .fill(fill_l),
            .wm(q_wmark[gq*CW +: CW]), .thr_hit(q_thr_hit[gq])
        );

        // Room and occupancy status feeding arbitration and output selection
        assign q_fill[gq*CW +: CW] = fill_l;
        assign room[gq]            = (fill_l < CW'(DEPTH));
        assign nonempty[gq]        = (fill_l != '0);
    end

    dtq_outsel #(.NUM_Q(NUM_Q), .QW(QW), .PRIO_W(PRIO_W)) i_out (
        .nonempty(nonempty), .prio(cfg_qprio), .out_ready(out_ready),
        .out_valid(out_valid), .out_q(out_q), .pop(pop)
    );

    // Offered channel comes from the head of the selected queue
    assign out_ch = head[out_q];

    // R2: a pending channel never leaves without going into a queue
    p_take_means_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take != '0) |-> (push != '0));
endmodule

// File: tb/test_dma_evt_qmgr.sv
`timescale 1ns/1ps
module test_dma_evt_qmgr;
    localparam int NUM_CH = 16, NUM_QCH = 4, NUM_Q = 4, DEPTH = 4, PRIO_W = 3;
    localparam int NUM_WORDS = 8, TRIG_WORD = 7;
    localparam int NT = NUM_CH + NUM_QCH, ID_W = $clog2(NT), QW = $clog2(NUM_Q);
    localparam int QCW = $clog2(NUM_QCH), WW = $clog2(NUM_WORDS), CW = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NUM_CH-1:0] man_set = '0, ext_evt = '0, chain_done = '0;
    logic qd_wr_en = 1'b0;
    logic [QCW-1:0] qd_wr_ch = '0;
    logic [WW-1:0] qd_wr_word = '0;
    logic [NT-1:0] miss_clr = '0;
    logic [NT*QW-1:0] cfg_qmap = '0;
    logic [NUM_Q*PRIO_W-1:0] cfg_qprio = '0;
    logic [NUM_Q*CW-1:0] cfg_qthresh = '0;
    logic [NUM_Q-1:0] wm_clr = '0;
    logic out_valid, out_ready = 1'b1;
    logic [ID_W-1:0] out_ch;
    logic [QW-1:0] out_q;
    logic [NT-1:0] miss;
    logic [NUM_Q*CW-1:0] q_fill, q_wmark;
    logic [NUM_Q-1:0] q_thr_hit;

    always #4 clk = ~clk;

    dma_evt_qmgr #(.NUM_CH(NUM_CH), .NUM_QCH(NUM_QCH), .NUM_Q(NUM_Q), .DEPTH(DEPTH),
                   .PRIO_W(PRIO_W), .NUM_WORDS(NUM_WORDS), .TRIG_WORD(TRIG_WORD)) i_dma_evt_qmgr (
        .clk(clk), .rst_n(rst_n), .man_set(man_set), .ext_evt(ext_evt),
        .chain_done(chain_done), .qd_wr_en(qd_wr_en), .qd_wr_ch(qd_wr_ch),
        .qd_wr_word(qd_wr_word), .miss_clr(miss_clr), .cfg_qmap(cfg_qmap),
        .cfg_qprio(cfg_qprio), .cfg_qthresh(cfg_qthresh), .wm_clr(wm_clr),
        .out_valid(out_valid), .out_ch(out_ch), .out_q(out_q), .out_ready(out_ready),
        .miss(miss), .q_fill(q_fill), .q_wmark(q_wmark), .q_thr_hit(q_thr_hit)
    );

    // Reference model state
    int fq [NUM_Q][$];
    logic [NT-1:0] m_pend = '0, m_miss = '0;
    int m_wm [NUM_Q];
    int n_chk = 0, n_fail = 0;
    string ph = "R1";

    function automatic int map_of(int i);
        return int'(cfg_qmap[i*QW +: QW]);
    endfunction
    function automatic int prio_of(int q);
        return int'(cfg_qprio[q*PRIO_W +: PRIO_W]);
    endfunction
    function automatic int model_best();
        int b = -1;
        for (int q = 0; q < NUM_Q; q++)
            if (fq[q].size() > 0 && (b < 0 || prio_of(q) < prio_of(b))) b = q;
        return b;
    endfunction

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // One clock of the reference model, using the inputs now on the pins
    task automatic model_step();
        int sz [NUM_Q];
        int b;
        logic [NT-1:0] p0, trig, take;
        if (!rst_n) begin
            m_pend = '0; m_miss = '0;
            for (int q = 0; q < NUM_Q; q++) begin fq[q].delete(); m_wm[q] = 0; end
            return;
        end
        p0 = m_pend;
        for (int q = 0; q < NUM_Q; q++) sz[q] = fq[q].size();
        b = model_best();
        if (b >= 0 && out_ready) void'(fq[b].pop_front());
        take = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            if (sz[q] < DEPTH) begin
                for (int i = 0; i < NT; i++) begin
                    if (p0[i] && map_of(i) == q) begin
                        fq[q].push_back(i); take[i] = 1'b1; break;
                    end
                end
            end
        end
        trig = '0;
        for (int i = 0; i < NUM_CH; i++) trig[i] = man_set[i] | ext_evt[i] | chain_done[i];
        if (qd_wr_en && int'(qd_wr_word) == TRIG_WORD) trig[NUM_CH + int'(qd_wr_ch)] = 1'b1;
        m_pend = (p0 & ~take) | (trig & ~p0);
        m_miss = (m_miss & ~miss_clr) | (trig & p0);
        for (int q = 0; q < NUM_Q; q++) begin
            if (wm_clr[q]) m_wm[q] = fq[q].size();
            else if (fq[q].size() > m_wm[q]) m_wm[q] = fq[q].size();
        end
    endtask

    task automatic compare_all();
        int b = model_best();
        chk(out_valid == (b >= 0), {ph, " R7 out_valid"}, out_valid, b >= 0);
        if (b >= 0 && out_valid) begin
            chk(int'(out_q) == b, {ph, " R7 out_q"}, out_q, b);
            chk(int'(out_ch) == fq[b][0], {ph, " R7 out_ch"}, out_ch, fq[b][0]);
        end
        chk(miss == m_miss, {ph, " R4 miss"}, miss, m_miss);
        for (int q = 0; q < NUM_Q; q++) begin
            int f = fq[q].size();
            int th = int'(cfg_qthresh[q*CW +: CW]);
            chk(int'(q_fill[q*CW +: CW]) == f, {ph, " R6 fill"}, q_fill[q*CW +: CW], f);
            chk(int'(q_wmark[q*CW +: CW]) == m_wm[q], {ph, " R8 wmark"}, q_wmark[q*CW +: CW], m_wm[q]);
            chk(q_thr_hit[q] == (m_wm[q] >= th), {ph, " R9 thr_hit"}, q_thr_hit[q], m_wm[q] >= th);
        end
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        compare_all();
        man_set = '0; ext_evt = '0; chain_done = '0; qd_wr_en = 1'b0;
        miss_clr = '0; wm_clr = '0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic set_map(input int i, input int q);
        cfg_qmap[i*QW +: QW] = QW'(q);
    endtask

    initial begin
        for (int i = 0; i < NT; i++) set_map(i, i % NUM_Q);
        for (int q = 0; q < NUM_Q; q++) begin
            cfg_qprio[q*PRIO_W +: PRIO_W] = PRIO_W'(q);
            cfg_qthresh[q*CW +: CW] = CW'(3);
        end
        // R1: reset state
        ph = "R1"; idle(3); rst_n = 1'b1; idle(1);
        // R2: each regular source, then all three together
        ph = "R2";
        man_set[2] = 1'b1; idle(4);
        ext_evt[9] = 1'b1; idle(4);
        chain_done[15] = 1'b1; idle(4);
        man_set[4] = 1'b1; ext_evt[4] = 1'b1; chain_done[4] = 1'b1; idle(4);
        // R3: wrong descriptor word, then the trigger word
        ph = "R3";
        qd_wr_en = 1'b1; qd_wr_ch = 2'd1; qd_wr_word = 3'd3; idle(3);
        qd_wr_en = 1'b1; qd_wr_ch = 2'd1; qd_wr_word = WW'(TRIG_WORD); idle(4);
        // R4: retrigger while pending, clear, clear colliding with a miss
        ph = "R4";
        man_set[6] = 1'b1; tick(); man_set[6] = 1'b1; idle(3);
        miss_clr[6] = 1'b1; idle(2);
        man_set[6] = 1'b1; tick(); man_set[6] = 1'b1; miss_clr[6] = 1'b1; idle(3);
        miss_clr = '1; idle(2);
        // R6: all channels on queue 0 with the output stalled
        ph = "R6";
        out_ready = 1'b0;
        for (int i = 0; i < NT; i++) set_map(i, 0);
        man_set = '1; idle(8);
        man_set[0] = 1'b1; idle(2);
        out_ready = 1'b1; idle(30);
        // R5: several channels per queue in one cycle, tied priorities
        ph = "R5";
        out_ready = 1'b0;
        for (int i = 0; i < NT; i++) set_map(i, (i / 3) % NUM_Q);
        man_set = 16'hF0F3; idle(6);
        cfg_qprio = {3'd0, 3'd1, 3'd1, 3'd2};
        out_ready = 1'b1; idle(20);
        // R8 and R9: watermark clear while filling, varied thresholds
        ph = "R8";
        wm_clr = '1; tick();
        cfg_qthresh = {CW'(3), CW'(4), CW'(2), CW'(0)};
        out_ready = 1'b0;
        man_set = 16'h0FFF; idle(2);
        wm_clr[1] = 1'b1; man_set = 16'hF000; idle(6);
        ph = "R9";
        out_ready = 1'b1; idle(6);
        wm_clr = 4'b0101; idle(10);
        // R7: randomized traffic with changing configuration
        ph = "R7";
        for (int n = 0; n < 3000; n++) begin
            if (n % 200 == 0) begin
                for (int i = 0; i < NT; i++) set_map(i, $urandom_range(NUM_Q - 1));
                cfg_qprio = PRIO_W*NUM_Q'($urandom);
                for (int q = 0; q < NUM_Q; q++) cfg_qthresh[q*CW +: CW] = CW'($urandom_range(DEPTH));
            end
            man_set = NUM_CH'($urandom & $urandom & $urandom);
            ext_evt = NUM_CH'($urandom & $urandom & $urandom & $urandom);
            chain_done = NUM_CH'($urandom & $urandom & $urandom & $urandom);
            qd_wr_en = ($urandom_range(3) == 0);
            qd_wr_ch = QCW'($urandom);
            qd_wr_word = ($urandom_range(1) == 0) ? WW'(TRIG_WORD) : WW'($urandom);
            miss_clr = ($urandom_range(7) == 0) ? NT'($urandom) : '0;
            wm_clr = ($urandom_range(15) == 0) ? NUM_Q'($urandom) : '0;
            out_ready = ((n / 400) % 2 == 0) ? ($urandom_range(3) != 0) : ($urandom_range(3) == 0);
            tick();
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule